// File: doc/BRIEF.md
# Time and Alarm Setting Menu

This block keeps the six editable values of a digital clock: the hours, minutes and seconds of the running time, and the hours, minutes and seconds of the alarm. A 3-bit mode code from an outside control state machine chooses which of the six values is being edited. While a value is being edited, the block drives a four-digit display. The two left-hand digits carry a menu tag: first the clock or alarm glyph, then the hour, minute or second glyph. The two right-hand digits carry the tens and units BCD digits of the chosen value.

The user holds an increment input to edit. Each slow tick, a one-cycle enable pulse in the system clock domain, then moves the chosen value up by one. The value wraps inside its legal range. Every stored value is also available as a two-digit BCD output, so the timekeeping and alarm-compare logic can read it. Segment decoding, button debounce and the mode state machine sit outside this block.

Top module: `time_alarm_setter`

## Requirements
- R1: Mode code 3'b001, 3'b010 and 3'b011 select clock hours, minutes and seconds. Mode code 3'b100, 3'b101 and 3'b110 select alarm hours, minutes and seconds.
- R2: In the three clock modes `disp_tag_a` is 4'b1110. In the three alarm modes it is 4'b1101.
- R3: `disp_tag_b` is 4'b1010 for an hours mode, 4'b1011 for a minutes mode and 4'b1100 for a seconds mode.
- R4: In a selecting mode, `disp_tens` and `disp_units` equal the tens and units BCD digits of the selected value. Each stored-value output carries tens in bits [7:4] and units in bits [3:0].
- R5: A clock edge that sees `slow_tick` and `inc_hold` both high adds one to the selected value only. The new value shows on the outputs in the following cycle.
- R6: Minutes and seconds (clock and alarm) count 00 to 59, and a step from 59 gives 00.
- R7: Hours (clock and alarm) count 00 to 23, and a step from 23 gives 00.
- R8: In mode 3'b000 and 3'b111 no value changes, and all four display digits are 4'b1111.
- R9: An edge with `rst_n` low clears all six values to 00.
- R10: An edge where only one of `slow_tick` and `inc_hold` is high leaves every value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse at the editing rate |
| inc_hold | input | 1 | Increment button, held level |
| mode_code | input | 3 | Field-select code from the control state machine |
| disp_tag_a | output | 4 | Leftmost digit: clock or alarm glyph |
| disp_tag_b | output | 4 | Second digit: hour, minute or second glyph |
| disp_tens | output | 4 | Tens digit of the selected value |
| disp_units | output | 4 | Units digit of the selected value |
| clk_hours | output | 8 | Clock hours, BCD |
| clk_minutes | output | 8 | Clock minutes, BCD |
| clk_seconds | output | 8 | Clock seconds, BCD |
| alm_hours | output | 8 | Alarm hours, BCD |
| alm_minutes | output | 8 | Alarm minutes, BCD |
| alm_seconds | output | 8 | Alarm seconds, BCD |

## Verification
The bench uses the default limits, 24 for hours and 60 for minutes and seconds. At these sizes one full sweep per field costs only a few hundred cycles. This lets the bench walk every one of the six values through its whole range and past its wrap, which covers every units-to-tens carry and both wrap points. After each step it compares all six values and the display, so a step that lands on a field other than the selected one is caught. The idle codes, single-input pulses and a reset in mid-run are also checked against a modular-arithmetic model.

// File: rtl/tas_pkg.sv
// Shared types and display codes for the time and alarm setting menu.
// Assumes digit codes are 4-bit and values fit in two BCD digits.
package tas_pkg;
    typedef logic [3:0] nib_t;

    typedef struct packed {
        nib_t tens;
        nib_t units;
    } bcd2_t;

    localparam int NUM_FIELDS = 6;

    localparam nib_t GLY_CLOCK  = 4'b1110;
    localparam nib_t GLY_ALARM  = 4'b1101;
    localparam nib_t GLY_HOUR   = 4'b1010;
    localparam nib_t GLY_MINUTE = 4'b1011;
    localparam nib_t GLY_SECOND = 4'b1100;
    localparam nib_t GLY_BLANK  = 4'b1111;
endpackage

// File: rtl/bcd_wrap_counter.sv
// Two-digit BCD counter that steps by one on an enable and wraps from
// LIMIT-1 to zero. Assumes 2 <= LIMIT <= 100. Reset is synchronous, active low.
module bcd_wrap_counter
    import tas_pkg::*;
#(
    parameter int LIMIT = 60
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    output bcd2_t value
);
    localparam int   TOP   = LIMIT - 1;
    localparam nib_t TOP_T = nib_t'(TOP / 10);
    localparam nib_t TOP_U = nib_t'(TOP % 10);

    logic at_top;
    logic units_nine;

    // Purpose: flag the wrap point and the units carry point.
    always_comb begin
        at_top     = (value.tens == TOP_T) && (value.units == TOP_U);
        units_nine = (value.units == 4'd9);
    end

    // Purpose: hold the value, step it with carry and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (step) begin
            if (at_top) begin
                value <= '0;
            end else if (units_nine) begin
                value.tens  <= value.tens + 4'd1;
                value.units <= 4'd0;
            end else begin
                value.units <= value.units + 4'd1;
            end
        end
    end

    // R9: reset clears the value
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (value == '0));

    // R10: the value holds without a step
    a_r10_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(value));

    // R6 and R7: a step from the last legal value lands on zero
    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && value.tens == TOP_T && value.units == TOP_U) |=> (value == '0));

    // R6 and R7: the value stays a legal BCD number below LIMIT
    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (value.units <= 4'd9) &&
        ((value.tens < TOP_T) || (value.tens == TOP_T && value.units <= TOP_U)));
endmodule

// File: rtl/field_mode_decode.sv
// Turns the 3-bit mode code into a one-hot field select and the two menu
// glyphs. Codes 000 and 111 select nothing. Purely combinational.
module field_mode_decode
    import tas_pkg::*;
(
    input  logic [2:0]            mode_code,
    output logic [NUM_FIELDS-1:0] sel,
    output logic                  active,
    output nib_t                  tag_a,
    output nib_t                  tag_b
);
    // Purpose: decode the mode into a field select and glyph pair.
    always_comb begin
        sel    = '0;
        active = 1'b0;
        tag_a  = GLY_BLANK;
        tag_b  = GLY_BLANK;
        if (mode_code != 3'b000 && mode_code != 3'b111) begin
            active = 1'b1;
            sel    = NUM_FIELDS'(1) << (mode_code - 3'd1);
            tag_a  = mode_code[2] ? GLY_ALARM : GLY_CLOCK;
            case (mode_code)
                3'b001, 3'b100: tag_b = GLY_HOUR;
                3'b010, 3'b101: tag_b = GLY_MINUTE;
                default:        tag_b = GLY_SECOND;
            endcase
        end
    end
endmodule

// File: rtl/digit_mux.sv
// Picks the selected field from a one-hot select and produces the four
// display digits. Blanks every digit when no field is active.
module digit_mux
    import tas_pkg::*;
(
    input  bcd2_t                 fields [NUM_FIELDS],
    input  logic [NUM_FIELDS-1:0] sel,
    input  logic                  active,
    input  nib_t                  tag_a,
    input  nib_t                  tag_b,
    output nib_t                  d_tag_a,
    output nib_t                  d_tag_b,
    output nib_t                  d_tens,
    output nib_t                  d_units
);
    bcd2_t picked;

    // Purpose: AND-OR select of the chosen field.
    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            picked = picked | (fields[i] & {8{sel[i]}});
        end
    end

    // Purpose: drive the digits, or blank them when idle.
    always_comb begin
        if (active) begin
            d_tag_a = tag_a;
            d_tag_b = tag_b;
            d_tens  = picked.tens;
            d_units = picked.units;
        end else begin
            d_tag_a = GLY_BLANK;
            d_tag_b = GLY_BLANK;
            d_tens  = GLY_BLANK;
            d_units = GLY_BLANK;
        end
    end
endmodule

// File: rtl/time_alarm_setter.sv
// Time and alarm setting menu: six BCD fields, one edited at a time,
// chosen by the mode code and stepped when the tick meets the held button.
// Assumes slow_tick is a one-cycle pulse in the clk domain.
module time_alarm_setter
    import tas_pkg::*;
#(
    parameter int HOUR_LIMIT   = 24,
    parameter int MINSEC_LIMIT = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick,
    input  logic       inc_hold,
    input  logic [2:0] mode_code,
    output logic [3:0] disp_tag_a,
    output logic [3:0] disp_tag_b,
    output logic [3:0] disp_tens,
    output logic [3:0] disp_units,
    output logic [7:0] clk_hours,
    output logic [7:0] clk_minutes,
    output logic [7:0] clk_seconds,
    output logic [7:0] alm_hours,
    output logic [7:0] alm_minutes,
    output logic [7:0] alm_seconds
);
    localparam int UNITS_PER_GROUP = 3;

    logic [NUM_FIELDS-1:0] sel;
    logic                  active;
    nib_t                  tag_a;
    nib_t                  tag_b;
    logic                  bump;
    bcd2_t                 field_val [NUM_FIELDS];

    field_mode_decode u_decode (
        .mode_code (mode_code),
        .sel       (sel),
        .active    (active),
        .tag_a     (tag_a),
        .tag_b     (tag_b)
    );

    // Purpose: an edit step needs both the tick and the held button.
    always_comb bump = slow_tick && inc_hold;

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
        localparam int LIM = ((gi % UNITS_PER_GROUP) == 0) ? HOUR_LIMIT : MINSEC_LIMIT;
        bcd_wrap_counter #(.LIMIT(LIM)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (bump && sel[gi]),
            .value (field_val[gi])
        );
    end

    digit_mux u_mux (
        .fields  (field_val),
        .sel     (sel),
        .active  (active),
        .tag_a   (tag_a),
        .tag_b   (tag_b),
        .d_tag_a (disp_tag_a),
        .d_tag_b (disp_tag_b),
        .d_tens  (disp_tens),
        .d_units (disp_units)
    );

    // Purpose: bring the stored values out as BCD pairs.
    always_comb begin
        clk_hours   = field_val[0];
        clk_minutes = field_val[1];
        clk_seconds = field_val[2];
        alm_hours   = field_val[3];
        alm_minutes = field_val[4];
        alm_seconds = field_val[5];
    end

    // R1: at most one field is selected
    a_r1_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R2: the clock glyph shows on the display in clock modes
    a_r2_clock_glyph: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code inside {3'b001, 3'b010, 3'b011}) |-> (disp_tag_a == GLY_CLOCK));

    // R4: the digits follow the edited value in a clock-hours mode
    a_r4_hours_digits: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'b001) |-> ({disp_tens, disp_units} == clk_hours));

    // R8: idle codes blank all four digits
    a_r8_idle_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'b000 || mode_code == 3'b111) |->
        ({disp_tag_a, disp_tag_b, disp_tens, disp_units} == 16'hFFFF));

    // R8: idle codes freeze every field
    a_r8_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'b000 || mode_code == 3'b111) |=>
        ($stable(clk_hours) && $stable(clk_minutes) && $stable(clk_seconds) &&
         $stable(alm_hours) && $stable(alm_minutes) && $stable(alm_seconds)));

    // R10: no step without both tick and button
    a_r10_no_bump_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(slow_tick && inc_hold) |=>
        ($stable(clk_hours) && $stable(alm_hours) && $stable(clk_minutes) &&
         $stable(alm_minutes) && $stable(clk_seconds) && $stable(alm_seconds)));
endmodule

// File: tb/time_alarm_setter_test.sv
// Sweep bench for the time and alarm setting menu: every field is walked
// through its full range and past its wrap against an arithmetic model.
module time_alarm_setter_test;
    localparam int CLK_PERIOD = 10;
    localparam int HOURS_LIM  = 24;
    localparam int MS_LIM     = 60;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       slow_tick;
    logic       inc_hold;
    logic [2:0] mode_code;
    logic [3:0] disp_tag_a, disp_tag_b, disp_tens, disp_units;
    logic [7:0] clk_hours, clk_minutes, clk_seconds;
    logic [7:0] alm_hours, alm_minutes, alm_seconds;

    int model [6];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    time_alarm_setter uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick   (slow_tick),
        .inc_hold    (inc_hold),
        .mode_code   (mode_code),
        .disp_tag_a  (disp_tag_a),
        .disp_tag_b  (disp_tag_b),
        .disp_tens   (disp_tens),
        .disp_units  (disp_units),
        .clk_hours   (clk_hours),
        .clk_minutes (clk_minutes),
        .clk_seconds (clk_seconds),
        .alm_hours   (alm_hours),
        .alm_minutes (alm_minutes),
        .alm_seconds (alm_seconds)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int lim_of(int idx);
        return ((idx % 3) == 0) ? HOURS_LIM : MS_LIM;
    endfunction

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_fields(string req);
        check(req, {8'h0, clk_hours},   {8'h0, to_bcd(model[0])});
        check(req, {8'h0, clk_minutes}, {8'h0, to_bcd(model[1])});
        check(req, {8'h0, clk_seconds}, {8'h0, to_bcd(model[2])});
        check(req, {8'h0, alm_hours},   {8'h0, to_bcd(model[3])});
        check(req, {8'h0, alm_minutes}, {8'h0, to_bcd(model[4])});
        check(req, {8'h0, alm_seconds}, {8'h0, to_bcd(model[5])});
    endtask

    task automatic check_display();
        if (mode_code == 3'b000 || mode_code == 3'b111) begin
            check("R8 blank", {disp_tag_a, disp_tag_b, disp_tens, disp_units}, 16'hFFFF);
        end else begin
            int idx = int'(mode_code) - 1;
            logic [3:0] exp_b;
            case (idx % 3)
                0:       exp_b = 4'b1010;
                1:       exp_b = 4'b1011;
                default: exp_b = 4'b1100;
            endcase
            check("R2 source glyph", {12'h0, disp_tag_a},
                  {12'h0, (idx >= 3) ? 4'b1101 : 4'b1110});
            check("R3 unit glyph", {12'h0, disp_tag_b}, {12'h0, exp_b});
            check("R1 R4 digits", {8'h0, disp_tens, disp_units}, {8'h0, to_bcd(model[idx])});
        end
    endtask

    // One cycle of stimulus, then the model update and checks after the edge.
    task automatic pulse(logic tk, logic inc, string req);
        @(negedge clk);
        slow_tick = tk;
        inc_hold  = inc;
        @(negedge clk);
        slow_tick = 1'b0;
        inc_hold  = 1'b0;
        if (tk && inc && mode_code != 3'b000 && mode_code != 3'b111) begin
            int idx = int'(mode_code) - 1;
            model[idx] = (model[idx] + 1) % lim_of(idx);
        end
        check_fields(req);
        check_display();
    endtask

    initial begin
        rst_n     = 1'b0;
        slow_tick = 1'b0;
        inc_hold  = 1'b0;
        mode_code = 3'b000;
        for (int i = 0; i < 6; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        check_fields("R9 reset state");
        check_display();
        rst_n = 1'b1;

        // Full sweep of each field through its wrap point.
        for (int m = 1; m <= 6; m++) begin
            mode_code = 3'(m);
            for (int s = 0; s < lim_of(m - 1) + 2; s++) begin
                pulse(1'b1, 1'b1, ((m - 1) % 3 == 0) ? "R5 R7 hour step" : "R5 R6 min/sec step");
                if (s % 7 == 3) begin
                    pulse(1'b1, 1'b0, "R10 tick only");
                    pulse(1'b0, 1'b1, "R10 button only");
                end
            end
        end

        // Idle codes must not step anything.
        for (int k = 0; k < 2; k++) begin
            mode_code = (k == 0) ? 3'b000 : 3'b111;
            for (int s = 0; s < 5; s++) pulse(1'b1, 1'b1, "R8 idle freeze");
        end

        // Mid-run reset clears all fields.
        mode_code = 3'b101;
        for (int s = 0; s < 4; s++) pulse(1'b1, 1'b1, "R5 step before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) model[i] = 0;
        check_fields("R9 mid-run reset");
        check_display();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule